// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose reads flow through to the data outputs in the cycle that follows the command edge. Writes need no bus turnaround cycle. A write command is registered on one rising edge, and its data is registered on the next enabled edge. The write then sits in a second stage until the edge after that, when it is committed to the array. A read that arrives while its address is still in the second stage gets the pending lanes merged over the array contents.

Storage is split into byte lanes of `LANE_W` bits. Each lane has its own active-low write enable.

The block is used as a cache or buffer memory behind a bus master. The master either loads an external address or advances a 2-bit burst counter. The counter steps through the low address bits in linear or interleaved order.

The block also provides:
- a clock-enable input that freezes the whole pipeline;
- an asynchronous output enable that gates only the drivers;
- a snooze input that silences the device until the next address load.

The data bus is split into `din`, `dout` and `dout_en`.

Top module: `zt_flow_sram`

## Requirements
- R1: A read command (`we_n`=1) sampled on an enabled edge with the device selected drives `dout_en`=1 during the following cycle. In that cycle `dout` equals the word at the command's address.
- R2: A write command (`we_n`=0 with at least one `lane_we_n` bit 0) takes its data from `din` on the next enabled edge. Lane i, which is `din[9i+8:9i]`, is stored only where `lane_we_n[i]` was 0 at the command edge. The other lanes keep their old contents.
- R3: `we_n`=0 with every `lane_we_n` bit 1 is an aborted write. It changes no stored word, and `dout_en` stays 0 in the next cycle.
- R4: On a load edge (`adv_ld`=0) the device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load without that selection gives `dout_en`=0 from the next cycle on. Later advance cycles stay deselected until a selected load.
- R5: On an advance edge (`adv_ld`=1) after a selected load, the command uses the next burst address. The upper address bits stay those of the loaded address. The select inputs are not looked at.
- R6: If `burst_ilv` was 1 at the load, the low two address bits of beat n (n=0..3) are start XOR n. If it was 0, they are (start + n) mod 4. The fifth beat wraps back to the start. Changing `burst_ilv` during a burst has no effect.
- R7: An edge with `ce_n`=1 changes nothing: after a read the output word is held, and after a write `dout_en` stays 0. The `din` value at that edge is ignored, and the pending write takes its data at the next edge with `ce_n`=0.
- R8: `oe_n`=1 forces `dout_en`=0 at once, without a clock edge. It does not alter the command sequence. A read with `oe_n`=1 returns data as soon as `oe_n` falls within that cycle.
- R9: While `snooze`=1, `dout_en` is 0 and commands are ignored. After snooze, advance cycles are deselected until a new selected load.
- R10: A read issued right after a write to the same address returns the new data in the written lanes and the old data in the other lanes.
- R11: After reset `dout_en` is 0, no burst is active and every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address, used on load edges |
| we_n | input | 1 | Active-low write command |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| sel_a_n | input | 1 | Active-low select, sampled at load |
| sel_b_n | input | 1 | Active-low select, sampled at load |
| sel_c | input | 1 | Active-high select, sampled at load |
| adv_ld | input | 1 | 0 = load external address, 1 = advance burst |
| ce_n | input | 1 | Active-low clock enable |
| oe_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Power-down request, active high |
| burst_ilv | input | 1 | Burst order at load: 1 = interleaved, 0 = linear |
| din | input | LANES*LANE_W | Write data, one cycle after the command |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
The hardest situation to reach is a read whose address still has a partial-lane write in the second write stage. Reaching it takes a write command, followed on the very next edge by a read of the same address while that write's data is being captured. The bench issues such a pair with only one of the two lanes enabled, so the word it reads back mixes new and old lanes.

A second hard case is a clock-enable stall placed between a write command and its data. The bench drives a junk word during the stall and checks that the word captured later is the one presented at the next enabled edge.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // low two address bits for burst beat n, from a start value
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       ilv);
        logic [1:0] sum;
        sum = start + n;
        return ilv ? (start ^ n) : sum;
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              hush,
    input  logic              load,
    input  logic              sel_ok,
    input  logic              ilv_in,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ok
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              ilv;
        logic              live;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] cnt_nx;

    always_comb begin
        cnt_nx = seq_q.cnt + 2'd1;
        if (load) begin
            cmd_addr = ext_addr;
            cmd_ok   = sel_ok;
        end else begin
            cmd_addr = {seq_q.base[ADDR_W-1 -: HI_W],
                        beat_lo(seq_q.base[1:0], cnt_nx, seq_q.ilv)};
            cmd_ok   = seq_q.live;
        end

        seq_d = seq_q;
        if (hush) begin
            seq_d.live = 1'b0;
        end else if (step) begin
            if (load) begin
                seq_d.base = ext_addr;
                seq_d.cnt  = 2'd0;
                seq_d.ilv  = ilv_in;
                seq_d.live = sel_ok;
            end else if (seq_q.live) begin
                seq_d.cnt = cnt_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R4: a load edge decides selection for the burst that follows
    a_r4_load_select: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hush && load) |=> (seq_q.live == $past(sel_ok)));

    // R5: advancing never disturbs the loaded base or the burst order
    a_r5_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hush && !load) |=> ($stable(seq_q.base) && $stable(seq_q.ilv)));

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (wr_en && wr_mask[l]) begin
                mem_q[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

endmodule

// File: rtl/zt_read_merge.sv
module zt_read_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic [LANES*LANE_W-1:0] byp_data,
    input  logic [LANES-1:0]        byp_mask,
    input  logic                    byp_hit,
    output logic [LANES*LANE_W-1:0] word
);

    for (genvar l = 0; l < LANES; l++) begin : g_pick
        assign word[l*LANE_W +: LANE_W] = (byp_hit && byp_mask[l])
                                        ? byp_data[l*LANE_W +: LANE_W]
                                        : arr_data[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zt_flow_sram.sv
module zt_flow_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    adv_ld,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic                    snooze,
    input  logic                    burst_ilv,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               s1_op;
        logic [ADDR_W-1:0] s1_addr;
        logic [LANES-1:0]  s1_mask;
        logic              s2_vld;
        logic [ADDR_W-1:0] s2_addr;
        logic [LANES-1:0]  s2_mask;
        logic [DATA_W-1:0] s2_data;
    } pipe_t;

    pipe_t st_d, st_q;

    logic              run, cmd_edge, sel_ok, load, wr_req, cmd_ok;
    logic              byp_hit, mem_we;
    op_e               op_new;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] arr_word, rd_word;

    always_comb begin
        run      = !ce_n || snooze;
        cmd_edge = !ce_n && !snooze;
        sel_ok   = !sel_a_n && !sel_b_n && sel_c;
        load     = !adv_ld;
        wr_req   = !we_n && (|(~lane_we_n));
        if (!cmd_ok)     op_new = OP_NONE;
        else if (we_n)   op_new = OP_RD;
        else if (wr_req) op_new = OP_WR;
        else             op_new = OP_NONE;

        st_d = st_q;
        if (run) begin
            st_d.s1_op   = cmd_edge ? op_new : OP_NONE;
            st_d.s1_addr = cmd_addr;
            st_d.s1_mask = ~lane_we_n;
            st_d.s2_vld  = cmd_edge && (st_q.s1_op == OP_WR);
            st_d.s2_addr = st_q.s1_addr;
            st_d.s2_mask = st_q.s1_mask;
            st_d.s2_data = din;
        end

        mem_we  = run && st_q.s2_vld;
        byp_hit = st_q.s2_vld && (st_q.s2_addr == st_q.s1_addr);
        dout_en = (st_q.s1_op == OP_RD) && !oe_n && !snooze;
        dout    = dout_en ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    zt_burst_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cmd_edge),
        .hush     (snooze),
        .load     (load),
        .sel_ok   (sel_ok),
        .ilv_in   (burst_ilv),
        .ext_addr (addr),
        .cmd_addr (cmd_addr),
        .cmd_ok   (cmd_ok)
    );

    zt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (st_q.s2_addr),
        .wr_mask (st_q.s2_mask),
        .wr_data (st_q.s2_data),
        .rd_addr (st_q.s1_addr),
        .rd_data (arr_word)
    );

    zt_read_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge (
        .arr_data (arr_word),
        .byp_data (st_q.s2_data),
        .byp_mask (st_q.s2_mask),
        .byp_hit  (byp_hit),
        .word     (rd_word)
    );

    // R3: an aborted write leaves the bus undriven in the next cycle
    a_r3_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !snooze && !we_n && (&lane_we_n)) |=> !dout_en);

    // R4: a load without full selection leaves the bus undriven
    a_r4_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !snooze && !adv_ld && !(!sel_a_n && !sel_b_n && sel_c)) |=> !dout_en);

    // R7: a stalled edge freezes both pipeline stages
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !snooze) |=> ($stable(st_q.s1_op) && $stable(st_q.s1_addr)
                               && $stable(st_q.s2_vld) && $stable(st_q.s2_data)));

    // R9: snooze keeps the drivers off
    a_r9_snooze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> !dout_en);

endmodule

// File: tb/test_zt_flow_sram.sv
module test_zt_flow_sram;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic        we_n;
    logic [1:0]  lane_we_n;
    logic        sel_a_n, sel_b_n, sel_c;
    logic        adv_ld, ce_n, oe_n, snooze, burst_ilv;
    logic [17:0] din;
    logic [17:0] dout;
    logic        dout_en;

    always #10 clk = ~clk;

    zt_flow_sram i_zt_flow_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .lane_we_n(lane_we_n),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .adv_ld(adv_ld),
        .ce_n(ce_n), .oe_n(oe_n), .snooze(snooze), .burst_ilv(burst_ilv),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // behavioural model
    logic [17:0] m_mem [64];
    bit          m_rd, m_wr, m_ilv, m_live;
    int          m_rd_addr, m_wr_addr, m_base, m_beat;
    bit [1:0]    m_wr_mask;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] pat(input int i);
        return 18'((i * 1237 + 99) % 262144);
    endfunction

    task automatic model_edge();
        int a, lo, sb;
        if (ce_n && !snooze) return;
        if (!snooze && m_wr) begin
            if (m_wr_mask[0]) m_mem[m_wr_addr][8:0]  = din[8:0];
            if (m_wr_mask[1]) m_mem[m_wr_addr][17:9] = din[17:9];
        end
        m_wr = 0;
        m_rd = 0;
        if (snooze) begin
            m_live = 0;
            return;
        end
        if (!adv_ld) begin
            m_base = int'(addr);
            m_beat = 0;
            m_ilv  = burst_ilv;
            m_live = !sel_a_n && !sel_b_n && sel_c;
            a = m_base;
        end else begin
            if (m_live) m_beat = (m_beat + 1) % 4;
            sb = m_base % 4;
            lo = m_ilv ? (sb ^ m_beat) : ((sb + m_beat) % 4);
            a = (m_base / 4) * 4 + lo;
        end
        if (!m_live) return;
        if (we_n) begin
            m_rd = 1;
            m_rd_addr = a;
        end else if (lane_we_n != 2'b11) begin
            m_wr = 1;
            m_wr_addr = a;
            m_wr_mask = ~lane_we_n;
        end
    endtask

    task automatic cycle(input string tag);
        logic exp_en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_en = m_rd && !oe_n && !snooze;
        check(tag, 18'(dout_en), 18'(exp_en));
        if (exp_en && dout_en) check(tag, dout, m_mem[m_rd_addr]);
    endtask

    task automatic go(input bit adv, input int a, input bit wen, input bit [1:0] ln,
                      input logic [17:0] d, input string tag);
        adv_ld = adv;
        addr = 6'(a);
        we_n = wen;
        lane_we_n = ln;
        din = d;
        cycle(tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        m_rd = 0; m_wr = 0; m_live = 0; m_ilv = 0; m_beat = 0; m_base = 0;
        m_rd_addr = 0; m_wr_addr = 0; m_wr_mask = '0;
        rst_n = 1'b0; addr = '0; we_n = 1'b1; lane_we_n = 2'b11;
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b0; adv_ld = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0; snooze = 1'b0; burst_ilv = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset", 18'(dout_en), 18'd0);
        cycle("R11");
        check("R11 idle", 18'(dout_en), 18'd0);
        sel_c = 1'b1;

        // R2 / R10 / R1: pipelined writes, partial lane, read right behind write
        go(0, 5,  0, 2'b00, 18'h0, "R2");
        go(0, 9,  0, 2'b00, 18'h2A5F3, "R2");
        go(0, 10, 0, 2'b10, 18'h1BEEF, "R2");
        go(0, 10, 1, 2'b11, 18'h0F00D, "R10");
        check("R10 merged", dout, {9'h000, 9'h00D});
        go(0, 5,  1, 2'b11, 18'h0, "R1");
        check("R1 read5", dout, 18'h2A5F3);
        go(0, 9,  1, 2'b11, 18'h0, "R1");
        check("R1 read9", dout, 18'h1BEEF);
        go(0, 9,  0, 2'b01, 18'h0, "R2");
        go(0, 9,  1, 2'b11, 18'h3FFFF, "R2");
        check("R2 lane1 only", dout, {9'h1FF, 9'h0EF});

        // R3: aborted write
        go(0, 5, 0, 2'b11, 18'h0, "R3");
        check("R3 no drive", 18'(dout_en), 18'd0);
        go(0, 5, 1, 2'b11, 18'h11111, "R3");
        check("R3 unchanged", dout, 18'h2A5F3);

        // R4: deselection
        sel_c = 1'b0;
        go(0, 5, 1, 2'b11, 18'h0, "R4");
        go(1, 0, 1, 2'b11, 18'h0, "R4");
        check("R4 adv desel", 18'(dout_en), 18'd0);
        sel_c = 1'b1; sel_a_n = 1'b1;
        go(0, 5, 1, 2'b11, 18'h0, "R4");
        sel_a_n = 1'b0; sel_b_n = 1'b1;
        go(0, 5, 1, 2'b11, 18'h0, "R4");
        sel_b_n = 1'b0;

        // R6 / R5: linear write burst fill, then reads in both orders
        burst_ilv = 1'b0;
        go(0, 16, 0, 2'b00, 18'h0, "R6");
        go(1, 0, 0, 2'b00, pat(0), "R5");
        go(1, 0, 0, 2'b00, pat(1), "R5");
        go(1, 0, 0, 2'b00, pat(2), "R5");
        go(0, 16, 1, 2'b11, pat(3), "R6");
        burst_ilv = 1'b1;
        go(0, 18, 1, 2'b11, 18'h0, "R6");
        sel_c = 1'b0;
        for (int k = 0; k < 4; k++) go(1, 0, 1, 2'b11, 18'h0, "R5");
        check("R6 ilv wrap", dout, pat(2));
        sel_c = 1'b1;
        go(0, 17, 1, 2'b11, 18'h0, "R6");
        go(1, 0, 1, 2'b11, 18'h0, "R6");
        check("R6 ilv beat1", dout, pat(0));
        go(1, 0, 1, 2'b11, 18'h0, "R6");
        burst_ilv = 1'b0;
        go(0, 17, 1, 2'b11, 18'h0, "R6");
        burst_ilv = 1'b1;
        for (int k = 0; k < 4; k++) go(1, 0, 1, 2'b11, 18'h0, "R6");
        check("R6 lin wrap", dout, pat(1));

        // R7: clock-enable stalls
        go(0, 5, 1, 2'b11, 18'h0, "R7");
        ce_n = 1'b1;
        go(0, 9, 0, 2'b00, 18'h0, "R7");
        go(1, 0, 0, 2'b00, 18'h0, "R7");
        check("R7 held", dout, 18'h2A5F3);
        ce_n = 1'b0;
        go(0, 12, 0, 2'b00, 18'h0, "R7");
        ce_n = 1'b1;
        go(0, 12, 1, 2'b11, 18'h3ABCD, "R7");
        check("R7 write stall quiet", 18'(dout_en), 18'd0);
        ce_n = 1'b0;
        go(0, 12, 1, 2'b11, 18'h31234, "R7");
        check("R7 late data", dout, 18'h31234);

        // R8: asynchronous output enable
        go(0, 5, 1, 2'b11, 18'h0, "R8");
        oe_n = 1'b1; #2;
        check("R8 off", 18'(dout_en), 18'd0);
        oe_n = 1'b0; #2;
        check("R8 on", 18'(dout_en), 18'd1);
        oe_n = 1'b1;
        go(0, 9, 1, 2'b11, 18'h0, "R8");
        oe_n = 1'b0; #2;
        check("R8 dummy read kept", dout, m_mem[9]);

        // R9: snooze
        go(0, 13, 0, 2'b00, 18'h0, "R9");
        go(0, 13, 1, 2'b11, 18'h2A5F3, "R9");
        snooze = 1'b1;
        go(0, 13, 0, 2'b00, 18'h1BEEF, "R9");
        go(0, 13, 1, 2'b11, 18'h1BEEF, "R9");
        check("R9 quiet", 18'(dout_en), 18'd0);
        snooze = 1'b0;
        go(1, 0, 1, 2'b11, 18'h0, "R9");
        check("R9 needs load", 18'(dout_en), 18'd0);
        go(0, 13, 1, 2'b11, 18'h0, "R9");
        check("R9 retained", dout, 18'h2A5F3);
        go(0, 0, 1, 2'b11, 18'h0, "R11");
        check("R11 unwritten zero", dout, 18'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule